// File: doc/BRIEF.md
# External Interrupt Request Controller

This block watches two external interrupt pins on behalf of a small 4-bit processor core. Each pin passes through a two-flop synchronizer and then an edge detector whose polarity comes from a per-channel waveform-select bit. A detected edge latches a per-channel request flag. The flag latches whatever the pin's port function is, because the controller has no notion of it.

A global enable, together with an in-service state and the per-channel enable bits, folds the flags into one request line to the core. The core sends one command per executed instruction: enable, disable, a test-and-clear of a single channel's flag, return from interrupt, or any other instruction. A separate acknowledge strobe accepts the pending request. Acceptance drops the global enable and marks the controller busy. The enable command takes hold one instruction late, so that an enable placed directly before a return leaves interrupts enabled once the return has executed.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset `req_flags`, `gie`, `busy`, `irq_req` and `skip` are all 0.
- R2: With `wave_rise[i]`=1 a 0-to-1 change on `pin_in[i]` sets `req_flags[i]`. With `wave_rise[i]`=0 a 1-to-0 change sets it. The flag shows 1 after the third rising clock edge that follows the pin change, and not before that edge.
- R3: A pin change in the direction opposite to the selected waveform leaves `req_flags[i]` at 0.
- R4: Rewriting `wave_rise[i]` so that the pin's present level becomes the active level sets `req_flags[i]` at the next rising clock edge.
- R5: The command code `cmd`=3 (test-and-clear) with `cmd_ch`=i has three effects at the clock edge where it is taken. It registers `skip`=1 exactly when `req_flags[i]` was 1. It clears `req_flags[i]`. It leaves the other channel's flag unchanged.
- R6: `irq_req` equals `gie` AND NOT `busy` AND (any `req_flags[i]` with `chan_en[i]`=1).
- R7: When `ack`=1 while `irq_req`=1, the next edge sets `busy`=1, clears `gie`, and clears the flag of the channel named by `irq_ch`. Channel 0 wins over channel 1 when both are pending.
- R8: While `busy`=1, `irq_req` stays 0 and `ack` changes neither `busy` nor `req_flags`.
- R9: `cmd`=1 (enable) sets `gie` only when the next command is taken. When enable is followed by `cmd`=4 (return), the result is `gie`=1 and `busy`=0. Other instructions use `cmd`=0.
- R10: `cmd`=2 (disable) clears `gie` and cancels an enable that has not yet taken effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NCH | Raw external pin levels |
| wave_rise | input | NCH | Waveform select per channel: 1 rising, 0 falling |
| chan_en | input | NCH | Per-channel request enable |
| cmd_valid | input | 1 | One pulse per executed instruction |
| cmd | input | 3 | Command: 0 other, 1 enable, 2 disable, 3 test-and-clear, 4 return |
| cmd_ch | input | CHW | Channel addressed by test-and-clear |
| ack | input | 1 | Core accepts the pending request |
| req_flags | output | NCH | Latched request flags |
| gie | output | 1 | Global interrupt enable |
| busy | output | 1 | Interrupt in service |
| irq_req | output | 1 | Request to the core |
| irq_ch | output | CHW | Channel that would be serviced |
| skip | output | 1 | Result of the last test-and-clear |

## Verification
The hardest state to reach is an enabled, pending request that arrives while the controller is already busy. To get there the bench first accepts channel 0 with channel 1 still flagged. It then issues enable followed by another instruction during service, so `gie` returns to 1 while `busy` holds the request off. Only the return command may release it, and that release must then select channel 1. The spurious set caused by rewriting the waveform-select bit is produced by holding a pin low and switching from rising to falling.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [2:0] {
        CMD_OTHER = 3'd0,
        CMD_EN    = 3'd1,
        CMD_DIS   = 3'd2,
        CMD_TST   = 3'd3,
        CMD_RET   = 3'd4
    } irq_cmd_e;

    typedef struct packed {
        logic gie;
        logic en_pend;
        logic busy;
    } irq_state_t;

    function automatic int unsigned idx_width(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/irq_edge_chan.sv
module irq_edge_chan #(
    parameter int unsigned SYNC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic rise,
    input  logic clr_tst,
    input  logic clr_ack,
    output logic flag
);
    logic [SYNC-1:0] sync_q;
    logic            prev_q;
    logic            lvl;
    logic            hit;

    // active level relative to the currently selected polarity
    assign lvl = rise ? sync_q[SYNC-1] : ~sync_q[SYNC-1];
    assign hit = lvl & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b1;
            flag   <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC-2:0], pin};
            prev_q <= lvl;
            flag   <= hit | (flag & ~clr_tst & ~clr_ack);
        end
    end

    // R5
    tst_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_tst && !hit) |=> !flag);

endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
    parameter int unsigned NCH = 2,
    localparam int unsigned CHW = irq_pkg::idx_width(NCH)
) (
    input  logic [NCH-1:0] req,
    output logic           any,
    output logic [CHW-1:0] idx,
    output logic [NCH-1:0] onehot
);
    always_comb begin
        idx    = '0;
        onehot = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx    = CHW'(i);
                onehot = '0;
                onehot[i] = 1'b1;
            end
        end
        any = |req;
    end
endmodule

// File: rtl/irq_core_ctl.sv
module irq_core_ctl
    import irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cmd_valid,
    input  irq_cmd_e cmd,
    input  logic     take,
    output logic     gie,
    output logic     busy
);
    irq_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (cmd_valid) begin
            if (st_q.en_pend) begin
                st_d.gie     = 1'b1;
                st_d.en_pend = 1'b0;
            end
            case (cmd)
                CMD_EN:  st_d.en_pend = 1'b1;
                CMD_DIS: begin
                    st_d.gie     = 1'b0;
                    st_d.en_pend = 1'b0;
                end
                CMD_RET: st_d.busy = 1'b0;
                default: ;
            endcase
        end
        if (take) begin
            st_d.gie     = 1'b0;
            st_d.en_pend = 1'b0;
            st_d.busy    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign gie  = st_q.gie;
    assign busy = st_q.busy;

    // R7
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> (busy && !gie));
    // R9
    ret_release_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd == CMD_RET && !take) |=> !busy);
    // R10
    dis_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd == CMD_DIS && !take) |=> !gie);
    // R9
    late_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.en_pend && cmd_valid && cmd != CMD_DIS && !take) |=> gie);

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned NCH  = 2,
    parameter int unsigned SYNC = 2,
    localparam int unsigned CHW = idx_width(NCH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] pin_in,
    input  logic [NCH-1:0] wave_rise,
    input  logic [NCH-1:0] chan_en,
    input  logic           cmd_valid,
    input  logic [2:0]     cmd,
    input  logic [CHW-1:0] cmd_ch,
    input  logic           ack,
    output logic [NCH-1:0] req_flags,
    output logic           gie,
    output logic           busy,
    output logic           irq_req,
    output logic [CHW-1:0] irq_ch,
    output logic           skip
);
    irq_cmd_e       cmd_e;
    logic           tst_hit;
    logic           take;
    logic           any_pend;
    logic [NCH-1:0] grant_vec;
    logic [NCH-1:0] clr_ack_vec;

    assign cmd_e   = irq_cmd_e'(cmd);
    assign tst_hit = cmd_valid && (cmd_e == CMD_TST);

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_chan
            irq_edge_chan #(.SYNC(SYNC)) u_chan (
                .clk     (clk),
                .rst     (rst),
                .pin     (pin_in[i]),
                .rise    (wave_rise[i]),
                .clr_tst (tst_hit && (cmd_ch == CHW'(i))),
                .clr_ack (clr_ack_vec[i]),
                .flag    (req_flags[i])
            );
        end
    endgenerate

    irq_prio #(.NCH(NCH)) u_prio (
        .req    (req_flags & chan_en),
        .any    (any_pend),
        .idx    (irq_ch),
        .onehot (grant_vec)
    );

    assign irq_req     = gie && !busy && any_pend;
    assign take        = ack && irq_req;
    assign clr_ack_vec = take ? grant_vec : '0;

    irq_core_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd       (cmd_e),
        .take      (take),
        .gie       (gie),
        .busy      (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) skip <= 1'b0;
        else     skip <= tst_hit && req_flags[cmd_ch];
    end

    // R7
    single_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr_ack_vec));

endmodule

// File: tb/tb_ext_irq_ctrl.sv
module tb_ext_irq_ctrl;
    localparam int NCH = 2;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] pin_in, wave_rise, chan_en;
    logic       cmd_valid, ack;
    logic [2:0] cmd;
    logic [0:0] cmd_ch;
    logic [1:0] req_flags;
    logic       gie, busy, irq_req, skip;
    logic [0:0] irq_ch;

    int compared = 0;
    int mismatched = 0;

    always #2 clk = ~clk;

    ext_irq_ctrl #(.NCH(NCH)) dut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .wave_rise(wave_rise),
        .chan_en(chan_en), .cmd_valid(cmd_valid), .cmd(cmd), .cmd_ch(cmd_ch),
        .ack(ack), .req_flags(req_flags), .gie(gie), .busy(busy),
        .irq_req(irq_req), .irq_ch(irq_ch), .skip(skip)
    );

    task automatic check(string tag, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic issue(int c, int ch);
        @(negedge clk);
        cmd_valid = 1'b1; cmd = 3'(c); cmd_ch = 1'(ch);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0; cmd = 3'd0;
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 flags", req_flags, 0);
        check("R1 gie", gie, 0);
        check("R1 busy", busy, 0);
        check("R1 irq_req", irq_req, 0);
        check("R1 skip", skip, 0);
    endtask

    task automatic t_rise();
        @(negedge clk); wave_rise[0] = 1'b1;
        wait_cyc(4);
        issue(3, 0);
        pin_in[0] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R2 rise early", req_flags[0], 0);
        @(posedge clk); @(negedge clk);
        check("R2 rise set", req_flags[0], 1);
    endtask

    task automatic t_fall();
        @(negedge clk); pin_in[1] = 1'b1;
        wait_cyc(5);
        issue(3, 1);
        check("R3 opposite edge ch1", req_flags[1], 0);
        pin_in[1] = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R2 fall early", req_flags[1], 0);
        @(posedge clk); @(negedge clk);
        check("R2 fall set", req_flags[1], 1);
    endtask

    task automatic t_opposite();
        issue(3, 0);
        pin_in[0] = 1'b0;
        wait_cyc(5);
        check("R3 opposite edge ch0", req_flags[0], 0);
    endtask

    task automatic t_polarity();
        wave_rise[0] = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R4 select rewrite sets", req_flags[0], 1);
        issue(3, 0);
        check("R5 skip taken", skip, 1);
        check("R5 flag cleared", req_flags[0], 0);
        check("R5 other untouched", req_flags[1], 1);
        issue(3, 0);
        check("R5 skip not taken", skip, 0);
    endtask

    task automatic t_service();
        wave_rise = 2'b11;
        wait_cyc(4);
        issue(3, 0);
        issue(3, 1);
        pin_in = 2'b11;
        wait_cyc(5);
        check("R2 both flags", req_flags, 3);
        chan_en = 2'b11;
        @(negedge clk);
        check("R6 gated by gie", irq_req, 0);
        issue(1, 0);
        check("R9 enable delayed", gie, 0);
        issue(0, 0);
        check("R9 enable applied", gie, 1);
        check("R6 request", irq_req, 1);
        check("R7 prio ch0", irq_ch, 0);
        pulse_ack();
        check("R7 gie cleared", gie, 0);
        check("R7 busy set", busy, 1);
        check("R7 flags after accept", req_flags, 2);
        issue(1, 0);
        issue(0, 0);
        check("R8 gie back", gie, 1);
        check("R8 held off", irq_req, 0);
        pulse_ack();
        check("R8 ack ignored busy", busy, 1);
        check("R8 ack ignored flags", req_flags, 2);
        issue(4, 0);
        check("R9 return busy", busy, 0);
        check("R6 request ch1", irq_req, 1);
        check("R7 ch1 selected", irq_ch, 1);
        chan_en[1] = 1'b0;
        @(negedge clk);
        check("R6 chan enable gate", irq_req, 0);
        chan_en[1] = 1'b1;
        pulse_ack();
        check("R7 ch1 cleared", req_flags, 0);
        issue(1, 0);
        issue(4, 0);
        check("R9 enable then return gie", gie, 1);
        check("R9 enable then return busy", busy, 0);
        issue(2, 0);
        check("R10 disable", gie, 0);
        issue(1, 0);
        issue(2, 0);
        issue(0, 0);
        check("R10 pending enable cancelled", gie, 0);
    endtask

    initial begin
        rst = 1'b1; pin_in = '0; wave_rise = '0; chan_en = '0;
        cmd_valid = 1'b0; cmd = '0; cmd_ch = '0; ack = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_rise();
        t_fall();
        t_opposite();
        t_polarity();
        t_service();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule